// File: doc/BRIEF.md
# Charge-Injection Threshold Scan Sequencer

This block runs an s-curve measurement of a detector read-out channel without help from software. It walks an injection DAC code from a start value towards a stop value in fixed steps. For every code it loads the DAC once. It then repeats a timed injection cycle a programmable number of times and counts how many of those injections the channel reported as hits. When the repeats for a code are finished, it emits one result word that holds the code and the hit count.

Each injection cycle has a fixed shape. The injection line is first held low for a clear phase, which resets the channel's hit latch and pulse-width counter. The line is then raised to inject charge, and the hit input is sampled only at the end of a propagation wait. An optional readout wait keeps the line high long enough for a pulse-width counter to stop. After the line drops, a settling wait follows, because the falling edge injects charge of the opposite sign. All phase lengths are parameters counted in clock cycles. The defaults suit a 40 MHz clock: 4000 cycles for 100 µs of propagation.

Top module: `scurve_scan_seq`

## Requirements
- R1: After reset, `inj`, `dac_load`, `res_valid`, `busy` and `done` are all low.
- R2: For each code of a scan, a single-cycle `dac_load` pulse presents that code on `dac_code` while `inj` is low, before any injection at that code.
- R3: Each injection cycle holds `inj` low for `T_RST` cycles, then high for `T_PROP` cycles, or for `T_PROP + T_TOT` cycles when `tot_en` was set at start. The first rise after a load comes `T_RST + 1` cycles after the load cycle.
- R4: Between two injections of the same code, `inj` stays low for exactly `T_SETTLE + T_RST` cycles.
- R5: `hit_in` is sampled once per injection, on the last clock edge of the propagation phase. A hit raised in cycle k after the rising clock edge of `inj` (k = 1 is the first cycle) is counted if and only if k ≤ `T_PROP`.
- R6: Each code is injected `repeats` times, and a value of 0 acts as 1. `res_hits` equals the number of counted hits for that code.
- R7: The codes visited are the start code, then the start code plus `code_step`, and so on, while the code stays at or below `code_last` and at or below the largest 12-bit code, 4095. The start code is always measured. A step of 0 measures only the start code.
- R8: While `res_valid` is high and `res_ready` is low, `res_valid`, `res_code` and `res_hits` hold their values.
- R9: `busy` is high from the cycle after an accepted start until the final result is taken. At that point `done` rises, and it stays high until the next start.
- R10: A `start` pulse while `busy` is high is ignored. Changes to the scan settings after the start has been accepted do not affect the scan in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a scan (taken only when idle) |
| code_first | input | CODE_W | First injection code |
| code_last | input | CODE_W | Highest code allowed |
| code_step | input | CODE_W | Code increment |
| repeats | input | CNT_W | Injections per code (0 acts as 1) |
| tot_en | input | 1 | Add the pulse-width readout wait |
| hit_in | input | 1 | Latched hit flag from the channel |
| inj | output | 1 | Injection control line |
| dac_code | output | CODE_W | Injection DAC code |
| dac_load | output | 1 | One-cycle DAC load strobe |
| res_valid | output | 1 | Result word available |
| res_ready | input | 1 | Result consumer ready |
| res_code | output | CODE_W | Code of the result |
| res_hits | output | CNT_W | Hits counted for that code |
| busy | output | 1 | Scan in progress |
| done | output | 1 | Scan finished |

## Verification
Two events can land on the same clock edge: the channel's hit flag rising, and the sequencer's sampling edge at the end of the propagation phase. The bench provokes this with a channel model that alternates between raising the hit in the last propagation cycle and raising it one cycle later. It then expects exactly half of the injections, rounded up, to be counted. A second collision, a start request arriving during a scan, is provoked together with altered settings. The bench judges it by checking that the result stream is still the one defined by the original settings.

// File: rtl/scan_pkg.sv
package scan_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_LOAD,
    PH_CLEAR,
    PH_PROP,
    PH_READ,
    PH_SETTLE,
    PH_EMIT
  } phase_e;

  // True when the code after 'cur' would leave the scan range.
  function automatic bit is_final(int unsigned cur, int unsigned step,
                                  int unsigned stop, int unsigned top_code);
    int unsigned nxt;
    nxt = cur + step;
    return (step == 0) || (nxt > stop) || (nxt > top_code);
  endfunction

  // Number of injections actually performed for a requested count.
  function automatic int unsigned eff_reps(int unsigned req);
    return (req == 0) ? 1 : req;
  endfunction

  function automatic int max4(int a, int b, int c, int d);
    int m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction

endpackage

// File: rtl/scan_timer.sv
module scan_timer #(
  parameter int LEN_W = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [LEN_W-1:0] len,
  output logic             expired
);

  logic [LEN_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)
      cnt_q <= '0;
    else if (load)
      cnt_q <= len - 1'b1;
    else if (cnt_q != '0)
      cnt_q <= cnt_q - 1'b1;
  end

  assign expired = (cnt_q == '0);

endmodule

// File: rtl/scan_tally.sv
module scan_tally #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic [CNT_W-1:0] reps_m1,
  input  logic             sample,
  input  logic             hit,
  input  logic             rep_step,
  output logic [CNT_W-1:0] hits,
  output logic             last_rep
);

  logic [CNT_W-1:0] left_q;
  logic [CNT_W-1:0] hits_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      left_q <= '0;
      hits_q <= '0;
    end else if (clr) begin
      left_q <= reps_m1;
      hits_q <= '0;
    end else begin
      if (rep_step) left_q <= left_q - 1'b1;
      if (sample && hit) hits_q <= hits_q + 1'b1;
    end
  end

  assign hits     = hits_q;
  assign last_rep = (left_q == '0);

  // R6
  rep_over_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rep_step |-> !last_rep);

endmodule

// File: rtl/scurve_scan_seq.sv
module scurve_scan_seq
  import scan_pkg::*;
#(
  parameter int CODE_W   = 12,
  parameter int CNT_W    = 16,
  parameter int T_RST    = 40,
  parameter int T_PROP   = 4000,
  parameter int T_TOT    = 4000,
  parameter int T_SETTLE = 8000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [CODE_W-1:0] code_first,
  input  logic [CODE_W-1:0] code_last,
  input  logic [CODE_W-1:0] code_step,
  input  logic [CNT_W-1:0]  repeats,
  input  logic              tot_en,
  input  logic              hit_in,
  output logic              inj,
  output logic [CODE_W-1:0] dac_code,
  output logic              dac_load,
  output logic              res_valid,
  input  logic              res_ready,
  output logic [CODE_W-1:0] res_code,
  output logic [CNT_W-1:0]  res_hits,
  output logic              busy,
  output logic              done
);

  localparam int T_MAX    = max4(T_RST, T_PROP, T_TOT, T_SETTLE);
  localparam int LEN_W    = $clog2(T_MAX + 1);
  localparam int CODE_MAX = (1 << CODE_W) - 1;

  phase_e phase_q, phase_d;

  logic [CODE_W-1:0] code_q, stop_q, step_q;
  logic [CNT_W-1:0]  reps_m1_q;
  logic              tot_q, busy_q, done_q;

  // Named internal events
  logic             t_load, t_exp;
  logic [LEN_W-1:0] t_len;
  logic             smp_now;
  logic             rep_step;
  logic             last_rep;
  logic             res_take;
  logic             final_code;
  logic             scan_end;
  logic             start_take;
  logic [CNT_W-1:0] hits;

  assign start_take = (phase_q == PH_IDLE) && start;
  assign smp_now    = (phase_q == PH_PROP) && t_exp;
  assign res_take   = (phase_q == PH_EMIT) && res_ready;
  assign final_code = is_final(32'(code_q), 32'(step_q), 32'(stop_q), CODE_MAX);
  assign scan_end   = res_take && final_code;

  always_comb begin
    phase_d  = phase_q;
    t_load   = 1'b0;
    t_len    = LEN_W'(T_RST);
    rep_step = 1'b0;
    unique case (phase_q)
      PH_IDLE:   if (start) phase_d = PH_LOAD;
      PH_LOAD: begin
        phase_d = PH_CLEAR;
        t_load  = 1'b1;
        t_len   = LEN_W'(T_RST);
      end
      PH_CLEAR: if (t_exp) begin
        phase_d = PH_PROP;
        t_load  = 1'b1;
        t_len   = LEN_W'(T_PROP);
      end
      PH_PROP: if (t_exp) begin
        t_load = 1'b1;
        if (tot_q) begin
          phase_d = PH_READ;
          t_len   = LEN_W'(T_TOT);
        end else begin
          phase_d = PH_SETTLE;
          t_len   = LEN_W'(T_SETTLE);
        end
      end
      PH_READ: if (t_exp) begin
        phase_d = PH_SETTLE;
        t_load  = 1'b1;
        t_len   = LEN_W'(T_SETTLE);
      end
      PH_SETTLE: if (t_exp) begin
        if (last_rep) begin
          phase_d = PH_EMIT;
        end else begin
          phase_d  = PH_CLEAR;
          t_load   = 1'b1;
          t_len    = LEN_W'(T_RST);
          rep_step = 1'b1;
        end
      end
      PH_EMIT: if (res_ready) phase_d = final_code ? PH_IDLE : PH_LOAD;
      default: phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q   <= PH_IDLE;
      code_q    <= '0;
      stop_q    <= '0;
      step_q    <= '0;
      reps_m1_q <= '0;
      tot_q     <= 1'b0;
      busy_q    <= 1'b0;
      done_q    <= 1'b0;
    end else begin
      phase_q <= phase_d;
      if (start_take) begin
        code_q    <= code_first;
        stop_q    <= code_last;
        step_q    <= code_step;
        reps_m1_q <= (repeats == '0) ? '0 : repeats - 1'b1;
        tot_q     <= tot_en;
        busy_q    <= 1'b1;
        done_q    <= 1'b0;
      end else if (res_take) begin
        if (final_code) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end else begin
          code_q <= code_q + step_q;
        end
      end
    end
  end

  scan_timer #(.LEN_W(LEN_W)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (t_load),
    .len    (t_len),
    .expired(t_exp)
  );

  scan_tally #(.CNT_W(CNT_W)) u_tally (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (phase_q == PH_LOAD),
    .reps_m1 (reps_m1_q),
    .sample  (smp_now),
    .hit     (hit_in),
    .rep_step(rep_step),
    .hits    (hits),
    .last_rep(last_rep)
  );

  assign inj       = (phase_q == PH_PROP) || (phase_q == PH_READ);
  assign dac_load  = (phase_q == PH_LOAD);
  assign dac_code  = code_q;
  assign res_valid = (phase_q == PH_EMIT);
  assign res_code  = code_q;
  assign res_hits  = hits;
  assign busy      = busy_q;
  assign done      = done_q;

  // R2
  load_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dac_load |-> !inj);

  // R2
  load_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dac_load |=> !dac_load);

  // R5
  smp_inj_chk: assert property (@(posedge clk) disable iff (!rst_n)
    smp_now |-> inj);

  // R8
  res_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_ready |=> res_valid && $stable(res_code) && $stable(res_hits));

  // R9
  done_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && busy));

  // R10
  start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && start && !res_take |=> busy && $stable(dac_code));

endmodule

// File: tb/scurve_scan_seq_test.sv
module scurve_scan_seq_test;
  localparam int CW = 12, NW = 16, TR = 3, TP = 10, TT = 6, TS = 12;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n = 1'b0, start = 1'b0, tot_en = 1'b0, hit_in = 1'b0, res_ready = 1'b1;
  logic [CW-1:0] code_first = '0, code_last = '0, code_step = '0;
  logic [NW-1:0] repeats = '0;
  logic inj, dac_load, res_valid, busy, done;
  logic [CW-1:0] dac_code, res_code;
  logic [NW-1:0] res_hits;

  scurve_scan_seq #(.CODE_W(CW), .CNT_W(NW), .T_RST(TR), .T_PROP(TP),
                    .T_TOT(TT), .T_SETTLE(TS)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .code_first(code_first),
    .code_last(code_last), .code_step(code_step), .repeats(repeats),
    .tot_en(tot_en), .hit_in(hit_in), .inj(inj), .dac_code(dac_code),
    .dac_load(dac_load), .res_valid(res_valid), .res_ready(res_ready),
    .res_code(res_code), .res_hits(res_hits), .busy(busy), .done(done));

  int n_chk = 0, n_bad = 0, cyc = 0;
  int exp_code [0:15];
  int exp_hits [0:15];
  int exp_n = 0, got_n = 0, load_n = 0;
  int hit_thr = 0, hit_mode = 0, exp_w = TP;
  int inj_idx = 0, cur_dly = 0, hi_len = 0, lo_len = 0, since_load = 0;
  bit prev_inj = 1'b0;

  task automatic check(string req, string what, int act, int expv);
    n_chk++;
    if (act != expv) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  function automatic int hit_delay(int code, int idx);
    if (hit_mode == 0) return (code >= hit_thr) ? 4 : 0;
    if (hit_mode == 1) return (idx % 2 == 0) ? TP : TP + 1;
    return 0;
  endfunction

  function automatic int hits_for(int code, int reps);
    if (hit_mode == 0) return (code >= hit_thr) ? reps : 0;
    if (hit_mode == 1) return (reps + 1) / 2;
    return 0;
  endfunction

  task automatic build_exp(int f, int l, int s, int r);
    int c, reps;
    reps = (r == 0) ? 1 : r;
    c = f;
    exp_n = 0;
    while (exp_n < 16) begin
      exp_code[exp_n] = c;
      exp_hits[exp_n] = hits_for(c, reps);
      exp_n++;
      if (s == 0) break;
      c = c + s;
      if (c > l || c > 4095) break;
    end
  endtask

  // Channel model and timing monitor
  always @(negedge clk) begin
    if (!rst_n) begin
      hit_in = 1'b0; prev_inj = 1'b0; hi_len = 0; lo_len = 0;
    end else begin
      since_load++;
      if (dac_load) begin
        check("R2", "inj during load", int'(inj), 0);
        if (load_n < 16) check("R2", "loaded code", int'(dac_code), exp_code[load_n]);
        load_n++;
        inj_idx = 0;
        since_load = 0;
      end
      if (inj && !prev_inj) begin
        if (inj_idx == 0) check("R3", "load to first rise", since_load, TR + 1);
        else check("R4", "low gap between injections", lo_len, TS + TR);
        cur_dly = hit_delay(int'(dac_code), inj_idx);
        hi_len = 0;
      end
      if (inj) begin
        hi_len++;
        if (hi_len == cur_dly) hit_in = 1'b1;
      end else begin
        if (prev_inj) begin
          check("R3", "inj high width", hi_len, exp_w);
          hit_in = 1'b0;
          inj_idx++;
          lo_len = 1;
        end else lo_len++;
      end
      prev_inj = inj;
      if (res_valid && res_ready) begin
        if (got_n < exp_n) begin
          check("R7", "result code", int'(res_code), exp_code[got_n]);
          check("R6", "result hits", int'(res_hits), exp_hits[got_n]);
        end
        got_n++;
      end
    end
  end

  task automatic run_scan(int f, int l, int s, int r, bit tot, int hold, bit meddle);
    int c0, h0, guard;
    bit ok;
    build_exp(f, l, s, r);
    got_n = 0; load_n = 0;
    exp_w = tot ? TP + TT : TP;
    @(negedge clk);
    code_first = CW'(f); code_last = CW'(l); code_step = CW'(s);
    repeats = NW'(r); tot_en = tot; res_ready = (hold == 0);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check("R9", "busy after start", int'(busy), 1);
    check("R9", "done cleared by start", int'(done), 0);
    if (meddle) begin
      repeat (5) @(negedge clk);
      code_first = CW'(f + 1); code_last = CW'(l + 50); repeats = NW'(r + 3);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    if (hold > 0) begin
      guard = 0;
      while (!res_valid && guard < 20000) begin @(negedge clk); guard++; end
      c0 = int'(res_code); h0 = int'(res_hits); ok = 1'b1;
      repeat (hold) begin
        @(negedge clk);
        if (!res_valid || int'(res_code) != c0 || int'(res_hits) != h0) ok = 1'b0;
      end
      check("R8", "result held under backpressure", int'(ok), 1);
      res_ready = 1'b1;
    end
    guard = 0;
    while (!done && guard < 40000) begin @(negedge clk); guard++; end
    check("R7", "result count", got_n, exp_n);
    check("R2", "load count", load_n, exp_n);
    check("R9", "busy after end", int'(busy), 0);
    check("R9", "done after end", int'(done), 1);
  endtask

  task automatic t_reset;
    check("R1", "inj", int'(inj), 0);
    check("R1", "dac_load", int'(dac_load), 0);
    check("R1", "res_valid", int'(res_valid), 0);
    check("R1", "busy", int'(busy), 0);
    check("R1", "done", int'(done), 0);
  endtask

  task automatic t_basic;
    hit_mode = 0; hit_thr = 20;
    run_scan(16, 24, 2, 5, 1'b0, 0, 1'b0);
  endtask

  task automatic t_tot;
    hit_mode = 0; hit_thr = 20;
    run_scan(30, 30, 1, 3, 1'b1, 0, 1'b0);
  endtask

  task automatic t_boundary;
    hit_mode = 1;   // R5: last propagation cycle counts, one later does not
    run_scan(5, 5, 1, 6, 1'b0, 0, 1'b0);
    run_scan(9, 9, 1, 7, 1'b1, 0, 1'b0);
  endtask

  task automatic t_range;
    hit_mode = 0; hit_thr = 4092;   // R7 top-of-range stop
    run_scan(4090, 4095, 4, 2, 1'b0, 0, 1'b0);
    hit_mode = 0; hit_thr = 0;      // R7 zero step, R6 zero repeats
    run_scan(7, 100, 0, 0, 1'b0, 0, 1'b0);
  endtask

  task automatic t_hold;
    hit_mode = 0; hit_thr = 0;      // R8 backpressure, R10 start while busy
    run_scan(1, 2, 1, 2, 1'b0, 20, 1'b1);
  endtask

  task automatic t_done;
    repeat (10) @(negedge clk);
    check("R9", "done persists", int'(done), 1);
    hit_mode = 2;
    run_scan(40, 41, 1, 2, 1'b0, 0, 1'b0);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      n_chk++; n_bad++;
      $display("FAIL R9 watchdog actual=running expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_basic;
    t_tot;
    t_boundary;
    t_range;
    t_hold;
    t_done;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule